// File: doc/BRIEF.md
# Flash Reset and Abort Sequencer

This block sits in the control logic of a flash memory and handles its active-low reset pin. The pin passes through a synchronizer and then through a pulse qualifier, so only a low level that lasts at least a minimum number of clock cycles counts as a reset. A qualified reset that arrives while the device is idle places the part in a low-power hold state. In that state the output drivers are released to high impedance and the command interface is held in reset. When the pin rises, the block counts two wake-up delays: reads are permitted after the shorter one and writes after the longer one.

A qualified reset that arrives while a program or erase is running is handled differently. The block sends a one-cycle kill request to the embedded operation and sets a sticky abort flag, so firmware can see that the target location or block now holds undefined data. It then runs a shutdown interval of fixed length. When that interval ends, the block looks at the pin. If the pin is already high, the wake-up delays start at once, counted from the end of the shutdown rather than from the pin's rising edge. If the pin is still low, the block enters the hold state and waits for the pin to rise.

While its reset request is high, the command interface is expected to return to array-read mode, load 80h into its status register and mark every block locked. The block has one synchronous active-high `rst` input for its own flops. Every delay is a parameter given in clock cycles.

Top module: `flash_reset_sequencer`

## Requirements
- R1: A low level on `rst_pin_n` is qualified only once the synchronized pin has been low for MIN_LOW consecutive clock cycles. A shorter low pulse has no effect on any output: `out_en`, `rd_ready` and `wr_ready` stay 1, and `low_pwr` and `iface_rst` stay 0.
- R2: When `op_busy` is 0, a qualified reset puts the block into hold. In hold, `low_pwr`=1, `iface_rst`=1, `out_en`=0, `rd_ready`=0 and `wr_ready`=0. This takes effect exactly SYNC_STAGES+MIN_LOW+1 clock edges after `rst_pin_n` falls, counting the first edge that samples the low level.
- R3: After release from hold, `rd_ready` rises exactly SYNC_STAGES+RD_REC+1 edges after `rst_pin_n` rises. `wr_ready` rises exactly SYNC_STAGES+WR_REC+1 edges after the rise, and it only rises when coming out of the wake-up phase.
- R4: `iface_rst` is 1 in hold and in shutdown and 0 at every other time. While it is 1 the command interface returns to array-read mode, sets its status to 80h and locks all blocks.
- R5: When `op_busy` is 1, a qualified reset produces a pulse on `op_abort` that lasts exactly one cycle and sets `abort_flag` in the same cycle. It then enters shutdown, where `out_en`=0, `iface_rst`=1 and `low_pwr`=0.
- R6: Shutdown lasts exactly SHUT_CYC cycles whatever the pin does during it.
- R7: If the pin is high when shutdown ends, `low_pwr` is never asserted. `rd_ready` rises SHUT_CYC+RD_REC edges after the `op_abort` pulse and `wr_ready` rises SHUT_CYC+WR_REC edges after it.
- R8: If the pin is still low when shutdown ends, the block enters hold (`low_pwr`=1) at edge SHUT_CYC after the `op_abort` pulse. From there recovery follows R3.
- R9: `abort_flag` stays 1 until a `cmd_accept` pulse arrives during normal operation (`wr_ready`=1), and that pulse clears it. A `cmd_accept` in any other state does not clear it.
- R10: `wr_ready`=1 implies `rd_ready`=1, and `out_en` and `iface_rst` are never 1 together.
- R11: After `rst`, the block is in normal operation: `out_en`, `rd_ready` and `wr_ready` are 1, and `iface_rst`, `low_pwr`, `op_abort` and `abort_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer itself |
| rst_pin_n | input | 1 | Asynchronous active-low flash reset pin |
| op_busy | input | 1 | A program or erase is in progress |
| cmd_accept | input | 1 | One-cycle pulse for each command the interface accepts |
| out_en | output | 1 | Enable for the data output drivers |
| iface_rst | output | 1 | Reset request to the command interface |
| op_abort | output | 1 | One-cycle kill request to the embedded operation |
| rd_ready | output | 1 | Reads permitted |
| wr_ready | output | 1 | Writes permitted |
| abort_flag | output | 1 | Sticky flag: an operation was interrupted |
| low_pwr | output | 1 | Block is in the low-power hold state |

## Verification
The hardest situation to reach is the one where the pin is released during a shutdown. The release has to reach the synchronizer early enough to arrive before the interval ends, yet an early release must not shorten the shutdown and must not move the start of the recovery count. The bench holds `op_busy` high and drives a qualified low. It releases the pin two cycles after `op_abort` appears, then measures both ready flags from the abort pulse and checks that hold was never entered. A second abort keeps the pin low past the end of the shutdown, so the same path is forced into hold instead.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HOLD = 2'd1,
        ST_SHUT = 2'd2,
        ST_WAKE = 2'd3
    } frs_state_e;

    typedef struct packed {
        logic out_en;
        logic iface_rst;
        logic rd_ok;
        logic wr_ok;
        logic low_pwr;
    } frs_ctl_t;

    function automatic int frs_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int frs_bits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/frs_sync.sv
module frs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/frs_pulse_qual.sv
module frs_pulse_qual #(
    parameter int MIN_LOW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_low,
    output logic qual
);
    localparam int LW = frs_pkg::frs_bits(MIN_LOW);
    localparam logic [LW-1:0] LIMIT = LW'(MIN_LOW);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || !lvl_low) low_cnt <= '0;
        else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
    end

    assign qual = (low_cnt == LIMIT);

    // R1
    qual_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (qual && !$past(rst)) |-> $past(lvl_low));
endmodule

// File: rtl/frs_seq.sv
module frs_seq
    import frs_pkg::*;
#(
    parameter int SHUT_CYC = 12,
    parameter int RD_REC   = 6,
    parameter int WR_REC   = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_hi,
    input  logic     qual,
    input  logic     op_busy,
    input  logic     cmd_accept,
    output frs_ctl_t ctl,
    output logic     op_abort,
    output logic     abort_flag
);
    localparam int CNT_W = frs_bits(frs_max3(SHUT_CYC, RD_REC, WR_REC));
    localparam logic [CNT_W-1:0] SHUT_LAST = CNT_W'(SHUT_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_REC - 1);
    localparam logic [CNT_W-1:0] RD_MARK   = CNT_W'(RD_REC);

    frs_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic            abort_q;
    logic            kill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_RUN;
            cnt     <= '0;
            abort_q <= 1'b0;
            kill_q  <= 1'b0;
        end else begin
            kill_q <= 1'b0;
            unique case (st)
                ST_RUN: begin
                    if (qual) begin
                        cnt <= '0;
                        if (op_busy) begin
                            st      <= ST_SHUT;
                            kill_q  <= 1'b1;
                            abort_q <= 1'b1;
                        end else begin
                            st <= ST_HOLD;
                        end
                    end else if (cmd_accept) begin
                        abort_q <= 1'b0;
                    end
                end
                ST_SHUT: begin
                    if (cnt == SHUT_LAST) begin
                        cnt <= '0;
                        st  <= pin_hi ? ST_WAKE : ST_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (pin_hi) begin
                        st  <= ST_WAKE;
                        cnt <= '0;
                    end
                end
                ST_WAKE: begin
                    if (qual) begin
                        st  <= ST_HOLD;
                        cnt <= '0;
                    end else if (cnt == WR_LAST) begin
                        st  <= ST_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        ctl.out_en    = (st == ST_RUN) || (st == ST_WAKE);
        ctl.iface_rst = (st == ST_HOLD) || (st == ST_SHUT);
        ctl.low_pwr   = (st == ST_HOLD);
        ctl.wr_ok     = (st == ST_RUN);
        ctl.rd_ok     = (st == ST_RUN) || ((st == ST_WAKE) && (cnt >= RD_MARK));
    end

    assign op_abort   = kill_q;
    assign abort_flag = abort_q;

    // R5
    abort_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        op_abort |-> (abort_flag && st == ST_SHUT));

    // R6
    shut_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(st) == ST_SHUT && st != ST_SHUT) |-> ($past(cnt) == SHUT_LAST));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(abort_q)) |-> ($past(cmd_accept) && $past(st) == ST_RUN));

    // R3
    wr_from_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(ctl.wr_ok)) |-> ($past(st) == ST_WAKE));
endmodule

// File: rtl/flash_reset_sequencer.sv
module flash_reset_sequencer
    import frs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 8,
    parameter int SHUT_CYC    = 12,
    parameter int RD_REC      = 6,
    parameter int WR_REC      = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_pin_n,
    input  logic op_busy,
    input  logic cmd_accept,
    output logic out_en,
    output logic iface_rst,
    output logic op_abort,
    output logic rd_ready,
    output logic wr_ready,
    output logic abort_flag,
    output logic low_pwr
);
    logic     pin_s;
    logic     qual;
    frs_ctl_t ctl;

    frs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rst_pin_n),
        .q   (pin_s)
    );

    frs_pulse_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk     (clk),
        .rst     (rst),
        .lvl_low (!pin_s),
        .qual    (qual)
    );

    frs_seq #(
        .SHUT_CYC (SHUT_CYC),
        .RD_REC   (RD_REC),
        .WR_REC   (WR_REC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pin_hi     (pin_s),
        .qual       (qual),
        .op_busy    (op_busy),
        .cmd_accept (cmd_accept),
        .ctl        (ctl),
        .op_abort   (op_abort),
        .abort_flag (abort_flag)
    );

    assign out_en    = ctl.out_en;
    assign iface_rst = ctl.iface_rst;
    assign rd_ready  = ctl.rd_ok;
    assign wr_ready  = ctl.wr_ok;
    assign low_pwr   = ctl.low_pwr;

    // R10
    wr_implies_rd_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> rd_ready);

    // R10
    drv_vs_ifrst_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_en && iface_rst));
endmodule

// File: tb/sim_flash_reset_sequencer.sv
module sim_flash_reset_sequencer;
    localparam int SYNC = 2;
    localparam int MINL = 8;
    localparam int SHUT = 12;
    localparam int RD   = 6;
    localparam int WR   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_pin_n = 1'b1;
    logic op_busy = 1'b0;
    logic cmd_accept = 1'b0;
    logic out_en, iface_rst, op_abort, rd_ready, wr_ready, abort_flag, low_pwr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_reset_sequencer #(
        .SYNC_STAGES(SYNC), .MIN_LOW(MINL), .SHUT_CYC(SHUT), .RD_REC(RD), .WR_REC(WR)
    ) u0 (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .op_busy(op_busy),
        .cmd_accept(cmd_accept), .out_en(out_en), .iface_rst(iface_rst),
        .op_abort(op_abort), .rd_ready(rd_ready), .wr_ready(wr_ready),
        .abort_flag(abort_flag), .low_pwr(low_pwr)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Count falling edges until op_abort or low_pwr shows; sel 0 = op_abort, 1 = low_pwr
    task automatic wait_for(input int sel, output int n);
        n = 0;
        while (n < 500) begin
            @(negedge clk);
            n++;
            if (sel == 0 && op_abort) break;
            if (sel == 1 && low_pwr) break;
        end
    endtask

    // Release the pin after rel_at cycles, record first rd_ready and wr_ready cycles
    task automatic watch_ready(input int rel_at, output int nrd, output int nwr, output bit saw_hold);
        int n = 0;
        nrd = -1;
        nwr = -1;
        saw_hold = 1'b0;
        while (nwr < 0 && n < 1000) begin
            if (n == rel_at) rst_pin_n = 1'b1;
            @(negedge clk);
            n++;
            if (low_pwr) saw_hold = 1'b1;
            if (rd_ready && nrd < 0) nrd = n;
            if (wr_ready) nwr = n;
        end
    endtask

    task automatic pulse_accept();
        cmd_accept = 1'b1;
        @(negedge clk);
        cmd_accept = 1'b0;
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 out_en", out_en, 1);
        check("R11 rd_ready", rd_ready, 1);
        check("R11 wr_ready", wr_ready, 1);
        check("R11 iface_rst", iface_rst, 0);
        check("R11 low_pwr", low_pwr, 0);
        check("R11 abort_flag", abort_flag, 0);
        check("R11 op_abort", op_abort, 0);
    endtask

    task automatic t_short_pulse();
        bit any = 1'b0;
        rst_pin_n = 1'b0;
        repeat (MINL - 1) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (!out_en || !rd_ready || !wr_ready || low_pwr || iface_rst) any = 1'b1;
        end
        check("R1 short pulse ignored", any, 0);
    endtask

    task automatic t_min_pulse();
        bit seen = 1'b0;
        int nrd, nwr;
        bit sh;
        rst_pin_n = 1'b0;
        repeat (MINL) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (low_pwr) seen = 1'b1;
        end
        check("R1 MIN_LOW pulse qualifies", seen, 1);
        rst_pin_n = 1'b1;
        watch_ready(100, nrd, nwr, sh);
        check("R1 recovers after MIN_LOW pulse", wr_ready, 1);
    endtask

    task automatic t_idle_reset();
        int n;
        int nrd, nwr;
        bit sh;
        rst_pin_n = 1'b0;
        wait_for(1, n);
        check("R2 hold latency", n, SYNC + MINL + 1);
        check("R2 out_en low", out_en, 0);
        check("R4 iface_rst in hold", iface_rst, 1);
        check("R2 rd_ready low", rd_ready, 0);
        check("R2 wr_ready low", wr_ready, 0);
        check("R5 no abort when idle", abort_flag, 0);
        repeat (30) @(negedge clk);
        check("R2 still holding", low_pwr, 1);
        watch_ready(0, nrd, nwr, sh);
        check("R3 rd recovery", nrd, SYNC + RD + 1);
        check("R3 wr recovery", nwr, SYNC + WR + 1);
        check("R4 iface_rst released", iface_rst, 0);
    endtask

    task automatic t_abort_early();
        int n, nrd, nwr;
        bit sh;
        op_busy = 1'b1;
        rst_pin_n = 1'b0;
        wait_for(0, n);
        check("R5 abort latency", n, SYNC + MINL + 1);
        check("R5 abort_flag set", abort_flag, 1);
        check("R5 out_en off in shutdown", out_en, 0);
        check("R5 iface_rst in shutdown", iface_rst, 1);
        check("R5 not low power", low_pwr, 0);
        op_busy = 1'b0;
        watch_ready(2, nrd, nwr, sh);
        check("R7 rd from shutdown end", nrd, SHUT + RD);
        check("R7 wr from shutdown end", nwr, SHUT + WR);
        check("R7 no hold entered", sh, 0);
        check("R9 flag survives recovery", abort_flag, 1);
        pulse_accept();
        check("R9 accept clears flag", abort_flag, 0);
    endtask

    task automatic t_abort_late();
        int n, nrd, nwr;
        bit bad = 1'b0;
        bit sh;
        op_busy = 1'b1;
        rst_pin_n = 1'b0;
        wait_for(0, n);
        @(negedge clk);
        op_busy = 1'b0;
        check("R5 op_abort one cycle", op_abort, 0);
        for (int i = 2; i < SHUT; i++) begin
            if (!iface_rst || low_pwr || out_en) bad = 1'b1;
            @(negedge clk);
        end
        if (!iface_rst || low_pwr || out_en) bad = 1'b1;
        check("R6 shutdown state held", bad, 0);
        @(negedge clk);
        check("R8 hold at shutdown end", low_pwr, 1);
        pulse_accept();
        check("R9 accept ignored in hold", abort_flag, 1);
        repeat (5) @(negedge clk);
        watch_ready(0, nrd, nwr, sh);
        check("R8 rd recovery from release", nrd, SYNC + RD + 1);
        check("R8 wr recovery from release", nwr, SYNC + WR + 1);
        pulse_accept();
        check("R9 accept clears in normal op", abort_flag, 0);
    endtask

    initial begin
        t_reset_state();
        t_short_pulse();
        t_idle_reset();
        t_min_pulse();
        t_abort_early();
        t_abort_late();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule